// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

A small arithmetic coprocessor that sits on a byte-wide register bus. Software loads operand bytes, then starts either an unsigned W×W multiply (W steps) or an unsigned 2W/W divide (2W steps) by writing the last operand. The unit does one step per clock. `busy` is high while a step sequence runs. The result registers change on every step, so a read taken part-way through a run returns a defined partial value. The default width is W = 8, which gives an 8×8 multiply in 8 cycles and a 16/8 divide in 16 cycles.

All accesses use one address bus. On a write, address 0 is the multiplicand. Address 1 is the multiplier and starts a multiply. Addresses 2 and 3 are the low and high dividend bytes. Address 4 is the divisor and starts a divide. On a read, addresses 0 and 1 return the low and high bytes of the quotient register, and addresses 2 and 3 return the low and high bytes of the result register, which holds the product or the remainder. Any other read address returns zero. `rdata` is combinational from `addr` and the register state. A start write that arrives while a run is in progress still performs its first action on the result register, and nothing else happens.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, the multiplicand is 0xFF, the dividend is 0xFFFF, the quotient and result registers read zero, and `busy` is low.
- R2: Any write to address 1 sets the result register to zero on that clock edge, whether or not a run is in progress. This overrides any step update due on the same edge.
- R3: A write to address 1 while idle loads the quotient register with {written byte, multiplicand}. It raises `busy` for exactly 8 cycles, after which the result register holds multiplicand × written byte.
- R4: Each multiply step adds the left-shifted multiplicand into the result register when bit 0 of the right-shifted multiplier is 1. Each divide step halves the shifted divisor and, if that value is not greater than the remainder, subtracts it and shifts a 1 into the quotient; otherwise it shifts in a 0. Both registers are observable after every step.
- R5: Any write to address 4 copies the current 16-bit dividend into the result register on that clock edge, whether or not a run is in progress.
- R6: A write to address 4 while idle starts a divide with the divisor pre-shifted left by 16. `busy` is high for exactly 16 cycles, after which the quotient register holds dividend / divisor and the result register holds dividend mod divisor.
- R7: A divide by zero ends with quotient 0xFFFF and remainder equal to the dividend.
- R8: A start write (address 1 or 4) during a run neither restarts nor alters the run's operands. The only effect of such a write is the one given in R2 or R5.
- R9: A write to address 2 replaces only dividend bits 7:0, and a write to address 3 replaces only bits 15:8.
- R10: Writes to the multiplicand or dividend during a run are stored for the next operation and do not change the run in progress.
- R11: Reads at addresses 0/1 return quotient bits 7:0 and 15:8, reads at addresses 2/3 return result bits 7:0 and 15:8, and any other read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from `addr` |
| busy | output | 1 | High while a multiply or divide is stepping |

## Verification
A write is captured on the edge after it is driven. The result-register load from R2 or R5 is visible at the first sample after that edge, before any step has run. Steps run on each of the next 8 or 16 edges, so final values are due 8 or 16 cycles after the start edge, and `busy` falls at that same point. A bench model advances on every rising edge with the same edge semantics. The checks sample `busy` and `rdata` half a period later and compare them against the model on every cycle, so partial values are checked as well as final ones. Directed checks also count `busy` cycles and compare final results against plain arithmetic.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          busy
);
  localparam int PW = 2 * W;
  localparam int SW = 3 * W;
  localparam int MUL_STEPS = W;
  localparam int DIV_STEPS = 2 * W;
  localparam int CW = $clog2(DIV_STEPS + 1);

  localparam logic [AW-1:0] A_MCAND  = AW'(0);
  localparam logic [AW-1:0] A_MPLR   = AW'(1);
  localparam logic [AW-1:0] A_DVD_LO = AW'(2);
  localparam logic [AW-1:0] A_DVD_HI = AW'(3);
  localparam logic [AW-1:0] A_DVSR   = AW'(4);
  localparam logic [AW-1:0] R_QUO_LO = AW'(0);
  localparam logic [AW-1:0] R_QUO_HI = AW'(1);
  localparam logic [AW-1:0] R_RES_LO = AW'(2);
  localparam logic [AW-1:0] R_RES_HI = AW'(3);

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] dvd_q;
  logic [PW-1:0] quot_q;
  logic [PW-1:0] res_q;
  logic [PW-1:0] acc_q;
  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          is_div_q;

  logic          wr_mplr, wr_dvsr;
  logic [SW-1:0] dsh_next;
  logic          fits;
  logic [PW-1:0] div_rem;
  logic [PW-1:0] mul_sum;

  assign busy     = cnt_q != '0;
  assign wr_mplr  = wr_en && addr == A_MPLR;
  assign wr_dvsr  = wr_en && addr == A_DVSR;
  assign dsh_next = sh_q >> 1;
  assign fits     = {{W{1'b0}}, res_q} >= dsh_next;
  assign div_rem  = res_q - dsh_next[PW-1:0];
  assign mul_sum  = res_q + acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q  <= '1;
      dvd_q    <= '1;
      quot_q   <= '0;
      res_q    <= '0;
      acc_q    <= '0;
      sh_q     <= '0;
      cnt_q    <= '0;
      is_div_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_MCAND)  mcand_q        <= wdata;
      if (wr_en && addr == A_DVD_LO) dvd_q[W-1:0]   <= wdata;
      if (wr_en && addr == A_DVD_HI) dvd_q[PW-1:W]  <= wdata;

      if (busy) begin
        cnt_q <= cnt_q - CW'(1);
        if (is_div_q) begin
          sh_q   <= dsh_next;
          quot_q <= {quot_q[PW-2:0], fits};
          if (fits) res_q <= div_rem;
        end else begin
          if (sh_q[0]) res_q <= mul_sum;
          sh_q  <= sh_q >> 1;
          acc_q <= acc_q << 1;
        end
      end

      if (wr_mplr) begin
        res_q <= '0;
        if (!busy) begin
          quot_q   <= {wdata, mcand_q};
          sh_q     <= SW'(wdata);
          acc_q    <= PW'(mcand_q);
          cnt_q    <= CW'(MUL_STEPS);
          is_div_q <= 1'b0;
        end
      end

      if (wr_dvsr) begin
        res_q <= dvd_q;
        if (!busy) begin
          sh_q     <= {wdata, {PW{1'b0}}};
          cnt_q    <= CW'(DIV_STEPS);
          is_div_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      R_QUO_LO: rdata = quot_q[W-1:0];
      R_QUO_HI: rdata = quot_q[PW-1:W];
      R_RES_LO: rdata = res_q[W-1:0];
      R_RES_HI: rdata = res_q[PW-1:W];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [W-1:0]    wdata,
  input logic            busy,
  input logic [W-1:0]    mcand_q,
  input logic [2*W-1:0]  dvd_q,
  input logic [2*W-1:0]  quot_q,
  input logic [2*W-1:0]  res_q
);
  logic [15:0] run_len;
  logic        mode_mul;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len  <= '0;
      mode_mul <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 16'd1 : 16'd0;
      if (!busy && wr_en && addr == AW'(1)) mode_mul <= 1'b1;
      if (!busy && wr_en && addr == AW'(4)) mode_mul <= 1'b0;
    end
  end

  assert_clear_on_mplr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> res_q == '0);

  assert_mul_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == AW'(1)) |=> (busy && quot_q == {$past(wdata), $past(mcand_q)}));

  assert_load_on_dvsr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> res_q == $past(dvd_q));

  // R3 and R6: run length is either the multiply or the divide step count
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 16'(W) || run_len == 16'(2*W)));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_mul && wr_en && addr == AW'(1)) |=> $stable(quot_q));

  assert_dvd_halves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> (dvd_q[2*W-1:W] == $past(dvd_q[2*W-1:W]) && dvd_q[W-1:0] == $past(wdata)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .mcand_q(mcand_q), .dvd_q(dvd_q), .quot_q(quot_q), .res_q(res_q)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;

  int nchk = 0;
  int nerr = 0;
  bit armed = 0;

  int m_mca, m_dvd, m_quo, m_res, m_cnt, m_div, m_msh, m_macc, m_dsh;
  bit was_busy;

  always #2 clk = ~clk;

  muldiv_unit dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .busy(busy));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_rd(int a);
    case (a)
      0: return m_quo & 8'hFF;
      1: return (m_quo >> 8) & 8'hFF;
      2: return m_res & 8'hFF;
      3: return (m_res >> 8) & 8'hFF;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mca = 8'hFF; m_dvd = 16'hFFFF; m_quo = 0; m_res = 0;
      m_cnt = 0; m_div = 0; m_msh = 0; m_macc = 0; m_dsh = 0;
    end else begin
      was_busy = (m_cnt != 0);
      if (was_busy) begin
        if (m_div != 0) begin
          m_dsh = m_dsh / 2;
          if (m_res >= m_dsh) begin
            m_res = m_res - m_dsh;
            m_quo = (m_quo * 2 + 1) & 16'hFFFF;
          end else m_quo = (m_quo * 2) & 16'hFFFF;
        end else begin
          if (m_msh % 2 == 1) m_res = (m_res + m_macc) & 16'hFFFF;
          m_msh = m_msh / 2;
          m_macc = (m_macc * 2) & 16'hFFFF;
        end
        m_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        case (int'(addr))
          0: m_mca = wdata;
          1: begin
            m_res = 0;
            if (!was_busy) begin
              m_quo = (int'(wdata) << 8) | m_mca;
              m_msh = wdata; m_macc = m_mca; m_cnt = 8; m_div = 0;
            end
          end
          2: m_dvd = (m_dvd & 16'hFF00) | wdata;
          3: m_dvd = (m_dvd & 16'h00FF) | (int'(wdata) << 8);
          4: begin
            m_res = m_dvd;
            if (!was_busy) begin
              m_dsh = int'(wdata) << 16; m_cnt = 16; m_div = 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model (R4, also covering R2 and R5 timing)
  always @(negedge clk) begin
    if (rst_n && armed) begin
      chk("R4 busy per cycle", int'(busy), int'(m_cnt != 0));
      chk("R4 rdata per cycle", int'(rdata), model_rd(int'(addr)));
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_en = 1'b0; addr = 3'(i % 4);
    end
  endtask

  task automatic peek(int a, output int v);
    @(posedge clk); #1;
    wr_en = 1'b0; addr = 3'(a);
    @(negedge clk); v = rdata;
  endtask

  task automatic read16(int lo, output int v);
    int b0, b1;
    peek(lo, b0);
    peek(lo + 1, b1);
    v = (b1 << 8) | b0;
  endtask

  task automatic count_busy(int peek_addr, output int first, output int n);
    n = 0;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #1;
      wr_en = 1'b0; addr = 3'(peek_addr);
      @(negedge clk);
      if (i == 0) first = rdata;
      if (busy) n++;
    end
  endtask

  task automatic mul_run(int a, int b);
    int first, n, q, r;
    wr(0, a); wr(1, b);
    count_busy(2, first, n);
    chk("R2 product cleared at start", first, 0);
    chk("R3 busy cycles multiply", n, 8);
    read16(0, q); read16(2, r);
    chk("R3 quotient register load", q, (b << 8) | a);
    chk("R3 product", r, a * b);
  endtask

  task automatic div_run(int nn, int d);
    int first, n, q, r;
    wr(2, nn & 8'hFF); wr(3, nn >> 8); wr(4, d);
    count_busy(2, first, n);
    chk("R5 dividend copied at start", first, nn & 8'hFF);
    chk("R6 busy cycles divide", n, 16);
    read16(0, q); read16(2, r);
    if (d == 0) begin
      chk("R7 zero divisor quotient", q, 16'hFFFF);
      chk("R7 zero divisor remainder", r, nn);
    end else begin
      chk("R6 quotient", q, nn / d);
      chk("R6 remainder", r, nn % d);
    end
  endtask

  initial begin
    #(4 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int v, first, n, q;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; armed = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    read16(0, v); chk("R1 quotient after reset", v, 0);
    read16(2, v); chk("R1 result after reset", v, 0);
    // R1 default multiplicand 0xFF used by first multiply
    wr(1, 3); idle(10);
    read16(0, v); chk("R1 default multiplicand in quotient", v, 16'h03FF);
    read16(2, v); chk("R1 default multiplicand product", v, 3 * 255);
    // R1 default dividend 0xFFFF
    wr(4, 16); count_busy(3, first, n);
    chk("R1 default dividend high byte", first, 8'hFF);
    read16(0, v); chk("R1 default dividend quotient", v, 16'hFFFF / 16);

    mul_run(0, 8'h5A);
    mul_run(8'hFF, 8'hFF);
    mul_run(8'h81, 8'h7E);
    mul_run(8'h5A, 0);

    div_run(16'h1234, 8'h07);
    div_run(16'hFFFF, 8'hFF);
    div_run(16'h00FE, 8'hFF);
    div_run(16'h1234, 0);
    div_run(0, 8'h05);

    // R9 high byte write keeps low byte
    wr(2, 8'h34); wr(3, 8'h12); wr(3, 8'h56); wr(4, 8'h10);
    idle(18);
    read16(0, v); chk("R9 dividend halves quotient", v, 16'h5634 / 16);
    read16(2, v); chk("R9 dividend halves remainder", v, 16'h5634 % 16);

    // R8 multiply start during a multiply
    wr(0, 8'h12); wr(1, 8'h34); idle(2);
    wr(1, 8'h99);
    peek(2, v); chk("R2 clear during run", v, 0);
    idle(12);
    read16(0, v); chk("R8 ignored start keeps operands", v, 16'h3412);
    chk("R8 run ended on time", int'(busy), 0);

    // R8 divide start during a divide
    wr(2, 8'hE8); wr(3, 8'h03); wr(4, 8'h07); idle(3);
    wr(4, 8'h00);
    peek(3, v); chk("R5 reload during run", v, 8'h03);
    idle(20);
    chk("R8 divide not restarted", int'(busy), 0);

    // R10 operand writes during a run
    wr(0, 8'h0B); wr(1, 8'h0D); idle(1);
    wr(0, 8'h0F); wr(2, 8'h00); wr(3, 8'h01);
    idle(10);
    read16(2, v); chk("R10 running multiply unaffected", v, 8'h0B * 8'h0D);
    mul_run(8'h0F, 2);
    wr(4, 8'h03); idle(18);
    read16(0, q); chk("R10 stored dividend used", q, 16'h0100 / 3);

    // R11 unmapped read addresses
    peek(5, v); chk("R11 unmapped read 5", v, 0);
    peek(7, v); chk("R11 unmapped read 7", v, 0);

    idle(2);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule